// File: doc/BRIEF.md
# Split-Port RAM with Registered Read Path

This block is a synchronous memory with one port that only writes and one port that only reads, each with its own clock, enable and address. A stored word holds a data field and its parity lanes side by side. An elaboration parameter picks the narrow shape (32 data bits with 4 parity bits) or the wide shape (64 data bits with 8 parity bits). Data and parity enter on separate input buses and leave on separate output buses.

A read loads a data latch in the read clock domain. A second parameter decides whether the output comes straight from that latch or from an output register behind it. The register has its own clock enable, its own synchronous clear and an active-low asynchronous clear. When both ports touch the same address on the same edge, a collision policy fixed at elaboration decides what the latch receives. A sleep input freezes every access while it is high.

Top module: `split_port_ram`

## Requirements
- R1: With `WIDE`=0 a word is 36 bits, packed as {parity[3:0], data[31:0]}. `wrPar`/`wrData` are stored together and come back on `rdPar`/`rdData` unchanged. With `WIDE`=1 the widths are 8 and 64.
- R2: With `sleep` low, a rising `wrClk` edge with `wrEn` high stores the word at `wrAddr`. A rising `rdClk` edge with `rdEn` high loads the latch from `rdAddr`. Both may happen in one cycle at different addresses.
- R3: `COLL_MODE`=COLL_READ_FIRST: on a same-edge read and write to one address, the latch receives the word stored before the write. The write still lands.
- R4: `COLL_MODE`=COLL_WRITE_FIRST: on such a collision, the latch receives the word being written.
- R5: `COLL_MODE`=COLL_NO_CHANGE: on such a collision, the latch keeps its previous value. The write still lands.
- R6: `latchRst` high together with `rdEn` clears the latch to zero on the read edge and overrides the read. With `rdEn` low, `latchRst` has no effect.
- R7: With `OUT_REG`=1, on a read edge with `outCe` high the output register clears if `outRst` is high and otherwise loads the latch. With `outCe` low it holds, whatever `outRst` is.
- R8: With `OUT_REG`=1, `arstN` low forces `rdData` and `rdPar` to zero at once, without a clock, and overrides every other control.
- R9: While `sleep` is high no write is stored. The latch and the output register hold, and the synchronous clears are ignored.
- R10: Read latency is one `rdClk` edge with `OUT_REG`=0 (output follows the latch) and two edges with `OUT_REG`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-port clock |
| rdClk | input | 1 | Read-port clock |
| arstN | input | 1 | Asynchronous clear of the output register, active low |
| sleep | input | 1 | Power-save gate; blocks all accesses and clears |
| wrEn | input | 1 | Write enable |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| wrPar | input | PAR_W | Write parity lanes |
| rdEn | input | 1 | Read enable, also gates the latch clear |
| rdAddr | input | ADDR_W | Read address |
| latchRst | input | 1 | Synchronous clear of the data latch |
| outRst | input | 1 | Synchronous clear of the output register |
| outCe | input | 1 | Output register clock enable |
| rdData | output | DATA_W | Read data |
| rdPar | output | PAR_W | Read parity lanes |

## Verification
The bench builds three narrow copies with a 16-word depth, so same-address collisions happen often under random traffic. The first copy is read-first with the output register, the second is write-first with latency one, and the third is no-change with the output register. All three get the same stimulus on one shared clock. This covers every collision policy and both read latencies in one run. The register clears, clock-enable hold, asynchronous clear and sleep gating are exercised on the two registered copies, and the latency-one copy shows the latch directly.

// File: rtl/split_port_ram_pkg.sv
package split_port_ram_pkg;

  typedef enum logic [1:0] {
    COLL_READ_FIRST  = 2'd0,
    COLL_WRITE_FIRST = 2'd1,
    COLL_NO_CHANGE   = 2'd2
  } collMode_e;

  // per-edge strobes from control to datapath
  typedef struct packed {
    logic memWe;     // store write word
    logic latchClr;  // clear read latch
    logic latchLoad; // load read latch
    logic latchNew;  // latch takes write word instead of stored word
    logic regClr;    // clear output register
    logic regLoad;   // load output register from latch
  } strobe_t;

  function automatic int dataWidth(input bit wide);
    return wide ? 64 : 32;
  endfunction

endpackage

// File: rtl/split_port_ram_ctrl.sv
module split_port_ram_ctrl
  import split_port_ram_pkg::*;
#(
  parameter int        ADDR_W    = 9,
  parameter collMode_e COLL_MODE = COLL_READ_FIRST
) (
  input  logic              sleep,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              latchRst,
  input  logic              outRst,
  input  logic              outCe,
  output strobe_t           stb
);

  logic rdAct;
  logic wrAct;
  logic sameAddr;
  logic collide;

  assign rdAct    = rdEn & ~sleep;
  assign wrAct    = wrEn & ~sleep;
  assign sameAddr = (rdAddr == wrAddr);
  assign collide  = rdAct & wrAct & sameAddr;

  always_comb begin
    stb           = '0;
    stb.memWe     = wrAct;
    stb.latchClr  = rdAct & latchRst;
    stb.latchLoad = rdAct & ~latchRst;
    stb.regClr    = outCe & ~sleep & outRst;
    stb.regLoad   = outCe & ~sleep & ~outRst;
    unique case (COLL_MODE)
      COLL_WRITE_FIRST: stb.latchNew = collide;
      COLL_NO_CHANGE: begin
        if (collide) stb.latchLoad = 1'b0;
      end
      default: stb.latchNew = 1'b0;
    endcase
  end

endmodule

// File: rtl/split_port_ram_dp.sv
module split_port_ram_dp
  import split_port_ram_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int WORD_W  = 36,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              arstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [WORD_W-1:0] wrWord,
  output logic [WORD_W-1:0] latchQ,
  output logic [WORD_W-1:0] outWord
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.memWe) store[wrAddr] <= wrWord;
  end

  always_ff @(posedge rdClk) begin
    if (stb.latchClr)       latchQ <= '0;
    else if (stb.latchLoad) latchQ <= stb.latchNew ? wrWord : store[rdAddr];
  end

  generate
    if (OUT_REG) begin : g_reg
      logic [WORD_W-1:0] regQ;
      always_ff @(posedge rdClk or negedge arstN) begin
        if (!arstN)           regQ <= '0;
        else if (stb.regClr)  regQ <= '0;
        else if (stb.regLoad) regQ <= latchQ;
      end
      assign outWord = regQ;
    end else begin : g_bypass
      assign outWord = latchQ;
    end
  endgenerate

endmodule

// File: rtl/split_port_ram.sv
module split_port_ram
  import split_port_ram_pkg::*;
#(
  parameter bit        WIDE      = 1'b0,
  parameter int        ADDR_W    = 9,
  parameter collMode_e COLL_MODE = COLL_READ_FIRST,
  parameter bit        OUT_REG   = 1'b1,
  localparam int       DATA_W    = dataWidth(WIDE),
  localparam int       PAR_W     = DATA_W / 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              arstN,
  input  logic              sleep,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PAR_W-1:0]  wrPar,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              latchRst,
  input  logic              outRst,
  input  logic              outCe,
  output logic [DATA_W-1:0] rdData,
  output logic [PAR_W-1:0]  rdPar
);

  localparam int WORD_W = DATA_W + PAR_W;

  strobe_t           stb;
  logic [WORD_W-1:0] wrWord;
  logic [WORD_W-1:0] latchWord;
  logic [WORD_W-1:0] outWord;

  assign wrWord = {wrPar, wrData};
  assign rdData = outWord[DATA_W-1:0];
  assign rdPar  = outWord[WORD_W-1 -: PAR_W];

  split_port_ram_ctrl #(
    .ADDR_W   (ADDR_W),
    .COLL_MODE(COLL_MODE)
  ) u_ctrl (
    .sleep   (sleep),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .rdEn    (rdEn),
    .rdAddr  (rdAddr),
    .latchRst(latchRst),
    .outRst  (outRst),
    .outCe   (outCe),
    .stb     (stb)
  );

  split_port_ram_dp #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .OUT_REG(OUT_REG)
  ) u_dp (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .arstN  (arstN),
    .stb    (stb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .wrWord (wrWord),
    .latchQ (latchWord),
    .outWord(outWord)
  );

endmodule

// File: rtl/split_port_ram_chk.sv
module split_port_ram_chk
  import split_port_ram_pkg::*;
#(
  parameter int        ADDR_W    = 9,
  parameter int        WORD_W    = 36,
  parameter collMode_e COLL_MODE = COLL_READ_FIRST,
  parameter bit        OUT_REG   = 1'b1
) (
  input logic              rdClk,
  input logic              arstN,
  input logic              sleep,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [WORD_W-1:0] wrWord,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              latchRst,
  input logic              outRst,
  input logic              outCe,
  input logic [WORD_W-1:0] latchWord,
  input logic [WORD_W-1:0] outWord
);

  logic collide;
  assign collide = rdEn & wrEn & ~sleep & ~latchRst & (rdAddr == wrAddr);

  // R6
  latch_clear_chk: assert property (@(posedge rdClk) disable iff (!arstN)
    (rdEn && latchRst && !sleep) |=> (latchWord == '0));

  // R9
  sleep_latch_hold_chk: assert property (@(posedge rdClk) disable iff (!arstN)
    sleep |=> $stable(latchWord));

  generate
    if (COLL_MODE == COLL_WRITE_FIRST) begin : g_wf
      // R4
      write_first_chk: assert property (@(posedge rdClk) disable iff (!arstN)
        collide |=> (latchWord == $past(wrWord)));
    end
    if (COLL_MODE == COLL_NO_CHANGE) begin : g_nc
      // R5
      no_change_chk: assert property (@(posedge rdClk) disable iff (!arstN)
        collide |=> $stable(latchWord));
    end
    if (OUT_REG) begin : g_out
      // R7
      out_clear_chk: assert property (@(posedge rdClk) disable iff (!arstN)
        (outCe && outRst && !sleep) |=> (outWord == '0));
      // R7
      out_hold_chk: assert property (@(posedge rdClk) disable iff (!arstN)
        !outCe |=> $stable(outWord));
      // R9
      sleep_out_hold_chk: assert property (@(posedge rdClk) disable iff (!arstN)
        sleep |=> $stable(outWord));
    end else begin : g_lat
      // R10
      bypass_latency_chk: assert property (@(posedge rdClk) disable iff (!arstN)
        1'b1 |-> (outWord == latchWord));
    end
  endgenerate

endmodule

bind split_port_ram split_port_ram_chk #(
  .ADDR_W   (ADDR_W),
  .WORD_W   (WORD_W),
  .COLL_MODE(COLL_MODE),
  .OUT_REG  (OUT_REG)
) u_chk (
  .rdClk    (rdClk),
  .arstN    (arstN),
  .sleep    (sleep),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrWord   (wrWord),
  .rdEn     (rdEn),
  .rdAddr   (rdAddr),
  .latchRst (latchRst),
  .outRst   (outRst),
  .outCe    (outCe),
  .latchWord(latchWord),
  .outWord  (outWord)
);

// File: tb/split_port_ram_tb.sv
module split_port_ram_tb;
  import split_port_ram_pkg::*;

  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        arstN = 1'b0;
  logic        sleep = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrPar = '0;
  logic        rdEn = 1'b0;
  logic [3:0]  rdAddr = '0;
  logic        latchRst = 1'b0;
  logic        outRst = 1'b0;
  logic        outCe = 1'b0;

  logic [31:0] dat [3];
  logic [3:0]  par [3];

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  // reference state
  logic [35:0] mdlMem [NW];
  logic [35:0] mdlLat [3];
  logic [35:0] mdlReg [3];

  always #5 clk = ~clk;

  split_port_ram #(.WIDE(1'b0), .ADDR_W(AW), .COLL_MODE(COLL_READ_FIRST), .OUT_REG(1'b1)) u_dut (
    .wrClk(clk), .rdClk(clk), .arstN(arstN), .sleep(sleep), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wrPar(wrPar), .rdEn(rdEn), .rdAddr(rdAddr), .latchRst(latchRst),
    .outRst(outRst), .outCe(outCe), .rdData(dat[0]), .rdPar(par[0]));

  split_port_ram #(.WIDE(1'b0), .ADDR_W(AW), .COLL_MODE(COLL_WRITE_FIRST), .OUT_REG(1'b0)) u_dutWf (
    .wrClk(clk), .rdClk(clk), .arstN(arstN), .sleep(sleep), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wrPar(wrPar), .rdEn(rdEn), .rdAddr(rdAddr), .latchRst(latchRst),
    .outRst(outRst), .outCe(outCe), .rdData(dat[1]), .rdPar(par[1]));

  split_port_ram #(.WIDE(1'b0), .ADDR_W(AW), .COLL_MODE(COLL_NO_CHANGE), .OUT_REG(1'b1)) u_dutNc (
    .wrClk(clk), .rdClk(clk), .arstN(arstN), .sleep(sleep), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wrPar(wrPar), .rdEn(rdEn), .rdAddr(rdAddr), .latchRst(latchRst),
    .outRst(outRst), .outCe(outCe), .rdData(dat[2]), .rdPar(par[2]));

  task automatic step(input string t0, input string t1, input string t2);
    logic [35:0] wWord;
    logic [35:0] oldLat [3];
    logic [35:0] expW;
    logic [35:0] gotW;
    string tag;
    @(posedge clk);
    wWord = {wrPar, wrData};
    for (int m = 0; m < 3; m++) oldLat[m] = mdlLat[m];
    if (!sleep && rdEn) begin
      for (int m = 0; m < 3; m++) begin
        if (latchRst) mdlLat[m] = '0;
        else if (wrEn && (rdAddr == wrAddr)) begin
          if (m == 0)      mdlLat[m] = mdlMem[rdAddr]; // R3 old word
          else if (m == 1) mdlLat[m] = wWord;          // R4 new word
          // m == 2: R5 hold
        end else mdlLat[m] = mdlMem[rdAddr];
      end
    end
    for (int m = 0; m < 3; m++) begin
      if (!arstN) mdlReg[m] = '0;
      else if (!sleep && outCe) mdlReg[m] = outRst ? 36'd0 : oldLat[m];
    end
    if (!sleep && wrEn) mdlMem[wrAddr] = wWord;
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      expW = (m == 1) ? mdlLat[m] : mdlReg[m];
      gotW = {par[m], dat[m]};
      tag  = (m == 0) ? t0 : ((m == 1) ? t1 : t2);
      vecs++;
      if (gotW !== expW) begin
        errs++;
        $display("FAIL %s inst%0d t=%0t got=%h exp=%h", tag, m, $time, gotW, expW);
      end
    end
  endtask

  task automatic stepAll(input string t);
    step(t, t, t);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin : stim
    for (int m = 0; m < 3; m++) begin
      mdlLat[m] = 'x;
      mdlReg[m] = '0;
    end
    @(negedge clk);
    // R8 reset state: async clear, latch cleared by its sync reset
    arstN = 1'b0; rdEn = 1'b1; latchRst = 1'b1; outCe = 1'b1;
    stepAll("R8");
    stepAll("R6");
    latchRst = 1'b0; rdEn = 1'b0; arstN = 1'b1;
    stepAll("R8");

    // R2 fill every word
    wrEn = 1'b1;
    for (int i = 0; i < NW; i++) begin
      wrAddr = 4'(i); wrData = 32'hC3C3_0000 + 32'(i * 77); wrPar = 4'(i ^ 5);
      stepAll("R2");
    end
    wrEn = 1'b0;

    // R10 read-back latency
    rdEn = 1'b1;
    for (int i = 0; i < NW; i++) begin
      rdAddr = 4'(NW - 1 - i);
      stepAll("R10");
    end
    rdEn = 1'b0;
    stepAll("R10");
    stepAll("R10");

    // R1 parity lanes travel with data
    wrEn = 1'b1; wrAddr = 4'd7; wrData = 32'h1234_5678; wrPar = 4'h9;
    stepAll("R1");
    wrEn = 1'b0; rdEn = 1'b1; rdAddr = 4'd7;
    stepAll("R1");
    rdEn = 1'b0;
    stepAll("R1");

    // R2 simultaneous read and write at different addresses
    wrEn = 1'b1; rdEn = 1'b1; wrAddr = 4'd3; rdAddr = 4'd4;
    wrData = 32'hDEAD_BEEF; wrPar = 4'hA;
    stepAll("R2");

    // R3 R4 R5 collisions, then back-to-back collisions
    wrAddr = 4'd5; rdAddr = 4'd5; wrData = 32'h0BAD_F00D; wrPar = 4'h6;
    step("R3", "R4", "R5");
    wrEn = 1'b0; rdAddr = 4'd9;
    step("R3", "R4", "R5");
    wrEn = 1'b1; wrAddr = 4'd6; rdAddr = 4'd6; wrData = 32'h1111_2222; wrPar = 4'h1;
    step("R3", "R4", "R5");
    wrData = 32'h3333_4444; wrPar = 4'h2;
    step("R3", "R4", "R5");
    wrEn = 1'b0; rdAddr = 4'd5;
    step("R3", "R4", "R5");
    stepAll("R3");

    // R6 latch clear with and without read enable
    rdAddr = 4'd2; latchRst = 1'b1;
    stepAll("R6");
    stepAll("R6");
    rdEn = 1'b1; latchRst = 1'b0;
    stepAll("R6");
    rdEn = 1'b0; latchRst = 1'b1;
    stepAll("R6");
    stepAll("R6");
    latchRst = 1'b0;

    // R7 register clear, hold with outCe low, clear ignored with outCe low
    outRst = 1'b1;
    stepAll("R7");
    outRst = 1'b0; outCe = 1'b0; rdEn = 1'b1; rdAddr = 4'd3;
    stepAll("R7");
    stepAll("R7");
    outRst = 1'b1;
    stepAll("R7");
    outRst = 1'b0; outCe = 1'b1;
    stepAll("R7");

    // R9 sleep blocks writes, reads and clears
    sleep = 1'b1; wrEn = 1'b1; wrAddr = 4'd2; wrData = 32'hFFFF_0000; wrPar = 4'hF;
    rdAddr = 4'd2; latchRst = 1'b1; outRst = 1'b1;
    stepAll("R9");
    stepAll("R9");
    sleep = 1'b0; wrEn = 1'b0; latchRst = 1'b0; outRst = 1'b0;
    stepAll("R9");
    stepAll("R9");
    stepAll("R9");

    // R8 asynchronous clear mid-stream overrides loads
    rdAddr = 4'd7;
    stepAll("R8");
    arstN = 1'b0;
    stepAll("R8");
    stepAll("R8");
    arstN = 1'b1;
    stepAll("R8");
    stepAll("R8");

    // mixed random traffic, dense collisions on a small array
    for (int n = 0; n < 800; n++) begin
      wrEn     = ($urandom % 100) < 60;
      rdEn     = ($urandom % 100) < 70;
      wrAddr   = 4'($urandom % 6);
      rdAddr   = 4'($urandom % 6);
      wrData   = $urandom;
      wrPar    = 4'($urandom);
      sleep    = ($urandom % 100) < 8;
      latchRst = ($urandom % 100) < 5;
      outRst   = ($urandom % 100) < 5;
      outCe    = ($urandom % 100) < 80;
      arstN    = ($urandom % 100) >= 2;
      step("R3", "R4", "R5");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule